// File: doc/BRIEF.md
# Scaled-Index Effective Address Unit

This unit forms a 32-bit memory address from three terms: a base register, an index register scaled by 1, 2, 4 or 8, and a displacement that can be absent, a sign-extended byte or a full 32-bit word. Both registers are read from an eight-entry snapshot of the general register file. The snapshot arrives as one flat vector on `reg_file`, and register k occupies bits `[32*k+31 : 32*k]`. The address generation stage of a pipeline uses the unit once it has decoded the operand form of an instruction. Segment translation, paging and prefix decoding take place elsewhere.

Any of the eight registers may act as the base, including the stack pointer at slot 4. A separate `base_none` input removes the base term, so that a scaled-index-plus-displacement address can be formed. Slot 4 cannot act as an index. Selecting it as the index means "no index term". If that selection also asks for a scale other than 1, the unit raises `bad_index`. The result is registered by default: `out_valid` marks a new address one cycle after `in_valid`. A parameter turns the output stage into pure combinational logic.

Top module: `ea_scaled_index`

## Requirements
- R1: Any register slot 0 to 7, including the stack pointer slot 4, can supply the base term when `base_none` is 0.
- R2: When `base_none` is 1, the base term is zero whatever the value of `base_sel`.
- R3: `scale_code` values 0, 1, 2 and 3 multiply the index register by 1, 2, 4 and 8.
- R4: An `index_sel` of 4 (stack pointer slot) gives an index term of zero.
- R5: `bad_index` is 1 exactly when `index_sel` is 4 and `scale_code` is not 0. Otherwise it is 0. The address is still formed, with no index term.
- R6: `disp_kind` selects the displacement: 0 none, 1 `disp_val[7:0]` sign-extended to 32 bits, 2 all of `disp_val`, 3 none.
- R7: The three terms are added modulo 2^32. Carries out of bit 31 are dropped.
- R8: With the registered output (the default), `ea` and `bad_index` reflect the inputs present at the clock edge where `in_valid` is 1, and `out_valid` is high for the cycle that follows that edge.
- R9: While `rst_n` is low, `out_valid`, `ea` and `bad_index` are all 0.
- R10: When `in_valid` is 0 at an edge, `ea` and `bad_index` keep their values and `out_valid` goes low, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand fields are valid this cycle |
| reg_file | input | 256 | Flat snapshot of eight 32-bit registers, slot k in bits 32k+31:32k |
| base_none | input | 1 | 1 removes the base term |
| base_sel | input | 3 | Base register slot |
| index_sel | input | 3 | Index register slot; 4 means no index |
| scale_code | input | 2 | Index scale: 1 << scale_code |
| disp_kind | input | 2 | 0 none, 1 byte, 2 word, 3 none |
| disp_val | input | 32 | Displacement field |
| out_valid | output | 1 | Address is new this cycle |
| ea | output | 32 | Effective address |
| bad_index | output | 1 | Scaled stack-pointer index requested |

## Verification
On every cycle the assertions check the valid timing, the hold of the outputs on idle edges, and the `bad_index` rule for every index and scale combination. They also check that an address made only of absent terms comes out as zero. The exact sums cannot be checked that way. Scaling by each factor, sign extension of a negative byte displacement, wrap-around past 2^32, and the stack pointer used as a base all depend on register contents. Only the bench's vector table, with its precomputed addresses, shows them.

// File: rtl/ea_scaled_index.sv
module ea_scaled_index #(
  parameter int AW        = 32,
  parameter int NREG      = 8,
  parameter int STACK_IDX = 4,
  parameter bit REG_OUT   = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [NREG*AW-1:0]    reg_file,
  input  logic                  base_none,
  input  logic [$clog2(NREG)-1:0] base_sel,
  input  logic [$clog2(NREG)-1:0] index_sel,
  input  logic [1:0]            scale_code,
  input  logic [1:0]            disp_kind,
  input  logic [AW-1:0]         disp_val,
  output logic                  out_valid,
  output logic [AW-1:0]         ea,
  output logic                  bad_index
);
  localparam int SW = $clog2(NREG);

  logic [AW-1:0] regs [NREG];
  for (genvar k = 0; k < NREG; k++) begin : g_unpack
    assign regs[k] = reg_file[k*AW +: AW];
  end

  logic          idx_is_sp;
  logic [AW-1:0] base_t, index_t, disp_t, sum;

  assign idx_is_sp = (index_sel == SW'(STACK_IDX));
  assign base_t    = base_none ? '0 : regs[base_sel];
  assign index_t   = idx_is_sp ? '0 : (regs[index_sel] << scale_code);

  always_comb begin
    unique case (disp_kind)
      2'd1:    disp_t = {{(AW-8){disp_val[7]}}, disp_val[7:0]};
      2'd2:    disp_t = disp_val;
      default: disp_t = '0;
    endcase
  end

  assign sum = base_t + index_t + disp_t;

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        out_valid <= 1'b0;
        ea        <= '0;
        bad_index <= 1'b0;
      end else begin
        out_valid <= in_valid;
        if (in_valid) begin
          ea        <= sum;
          bad_index <= idx_is_sp && (scale_code != 2'd0);
        end
      end
    end
  end else begin : g_comb
    assign out_valid = in_valid;
    assign ea        = sum;
    assign bad_index = idx_is_sp && (scale_code != 2'd0);
  end
endmodule

// File: rtl/ea_scaled_index_chk.sv
module ea_scaled_index_chk #(
  parameter int AW        = 32,
  parameter int NREG      = 8,
  parameter int STACK_IDX = 4,
  parameter bit REG_OUT   = 1'b1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    base_none,
  input logic [$clog2(NREG)-1:0] index_sel,
  input logic [1:0]              scale_code,
  input logic [1:0]              disp_kind,
  input logic                    out_valid,
  input logic [AW-1:0]           ea,
  input logic                    bad_index
);
  localparam int SW = $clog2(NREG);
  logic sp_idx;
  assign sp_idx = (index_sel == SW'(STACK_IDX));

  if (REG_OUT) begin : g_chk
    assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
    assert_idle_no_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(ea) && $stable(bad_index)));
    assert_bad_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && sp_idx && scale_code != 2'd0) |=> bad_index);
    assert_bad_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !(sp_idx && scale_code != 2'd0)) |=> !bad_index);
    assert_all_absent_R2_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && base_none && sp_idx && (disp_kind == 2'd0 || disp_kind == 2'd3)) |=> (ea == '0));
    assert_reset_state_R9: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && ea == '0 && !bad_index));
  end
endmodule

bind ea_scaled_index ea_scaled_index_chk #(
  .AW(AW), .NREG(NREG), .STACK_IDX(STACK_IDX), .REG_OUT(REG_OUT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .base_none(base_none),
  .index_sel(index_sel), .scale_code(scale_code), .disp_kind(disp_kind),
  .out_valid(out_valid), .ea(ea), .bad_index(bad_index)
);

// File: tb/tb_ea_scaled_index.sv
module tb_ea_scaled_index;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;

  typedef struct packed {
    logic        bnone;
    logic [2:0]  bsel;
    logic [2:0]  isel;
    logic [1:0]  scl;
    logic [1:0]  dk;
    logic [31:0] disp;
    logic [31:0] exp_ea;
    logic        exp_bad;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{1'b0, 3'd3, 3'd1, 2'd2, 2'd1, 32'h0000_0006, 32'h0000_3046, 1'b0},
    '{1'b0, 3'd4, 3'd4, 2'd0, 2'd0, 32'h0000_0000, 32'h0000_7FF0, 1'b0},
    '{1'b1, 3'd5, 3'd1, 2'd3, 2'd2, 32'h0000_0100, 32'h0000_0180, 1'b0},
    '{1'b0, 3'd0, 3'd7, 2'd1, 2'd1, 32'h0000_00FC, 32'h0000_1004, 1'b0},
    '{1'b0, 3'd5, 3'd1, 2'd0, 2'd2, 32'h0000_0020, 32'h0000_0020, 1'b0},
    '{1'b0, 3'd6, 3'd6, 2'd3, 2'd0, 32'h0000_0000, 32'h8000_0000, 1'b0},
    '{1'b0, 3'd3, 3'd4, 2'd2, 2'd0, 32'h0000_0000, 32'h0000_3000, 1'b1},
    '{1'b0, 3'd2, 3'd3, 2'd0, 2'd3, 32'h0000_DEAD, 32'h0002_3000, 1'b0},
    '{1'b1, 3'd1, 3'd4, 2'd0, 2'd1, 32'h1234_5680, 32'hFFFF_FF80, 1'b0},
    '{1'b0, 3'd1, 3'd2, 2'd1, 2'd2, 32'hFFFF_FFFF, 32'h0004_000F, 1'b0}
  };
  localparam string TAGS [NV] = '{"R1 R3 R6", "R1 R4", "R2 R3", "R3 R6",
    "R7", "R3 R7", "R5", "R6", "R2 R6", "R3 R6 R7"};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [255:0] reg_file;
  logic        base_none = 1'b0;
  logic [2:0]  base_sel = '0, index_sel = '0;
  logic [1:0]  scale_code = '0, disp_kind = '0;
  logic [31:0] disp_val = '0;
  logic        out_valid, bad_index;
  logic [31:0] ea;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign reg_file = {32'h0000_0004, 32'h8000_0000, 32'hFFFF_FFF0, 32'h0000_7FF0,
                     32'h0000_3000, 32'h0002_0000, 32'h0000_0010, 32'h0000_1000};

  ea_scaled_index dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .reg_file(reg_file),
    .base_none(base_none), .base_sel(base_sel), .index_sel(index_sel),
    .scale_code(scale_code), .disp_kind(disp_kind), .disp_val(disp_val),
    .out_valid(out_valid), .ea(ea), .bad_index(bad_index)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v, input bit vld);
    base_none = v.bnone; base_sel = v.bsel; index_sel = v.isel;
    scale_code = v.scl; disp_kind = v.dk; disp_val = v.disp; in_valid = vld;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R9 out_valid", 32'(out_valid), 32'd0);
    check(ea == 32'd0, "R9 ea", ea, 32'd0);
    check(bad_index == 1'b0, "R9 bad_index", 32'(bad_index), 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i], 1'b1);
      @(negedge clk);
      check(ea == VEC[i].exp_ea, TAGS[i], ea, VEC[i].exp_ea);
      check(bad_index == VEC[i].exp_bad, {"R5 flag ", TAGS[i]}, 32'(bad_index), 32'(VEC[i].exp_bad));
      check(out_valid == 1'b1, "R8 out_valid", 32'(out_valid), 32'd1);
    end

    // R10: idle edge with a vector that would change both outputs
    drive(VEC[6], 1'b0);
    @(negedge clk);
    check(ea == VEC[NV-1].exp_ea, "R10 ea hold", ea, VEC[NV-1].exp_ea);
    check(bad_index == 1'b0, "R10 bad hold", 32'(bad_index), 32'd0);
    check(out_valid == 1'b0, "R10 out_valid low", 32'(out_valid), 32'd0);

    // R8: accept at the next edge, not before
    in_valid = 1'b1;
    #1;
    check(ea == VEC[NV-1].exp_ea, "R8 no early update", ea, VEC[NV-1].exp_ea);
    @(negedge clk);
    check(ea == VEC[6].exp_ea, "R8 update", ea, VEC[6].exp_ea);
    check(bad_index == 1'b1, "R8 R5 flag", 32'(bad_index), 32'd1);

    // R4/R5: SP index with scale 1 is legal and contributes nothing
    drive('{1'b1, 3'd0, 3'd4, 2'd0, 2'd2, 32'h0000_0040, 32'h0, 1'b0}, 1'b1);
    @(negedge clk);
    check(ea == 32'h40, "R4 no index", ea, 32'h40);
    check(bad_index == 1'b0, "R5 scale one legal", 32'(bad_index), 32'd0);

    // R9: reset mid-stream clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    check(ea == 32'd0 && !out_valid && !bad_index, "R9 re-reset", ea, 32'd0);
    rst_n = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule